// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is a bank of general-purpose pins behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and registered read data. Each pin has its own direction bit. The output levels live in a data register that can be overwritten as a whole. It can also be changed atomically through write-one set and write-one clear aliases. Incoming pin levels pass through a two-stage synchroniser before anything reads them or uses them for detection.

Each pin can raise an event on four conditions, enabled independently and in any combination: a low level, a high level, a rising transition and a falling transition. Every event is latched into two sticky pending vectors, one for each interrupt line. Software clears each vector by writing ones to its status register. Each line has its own enable mask, changed through set and clear aliases. An interrupt output is high while any of its pending bits has the enable bit set. Raw views show the pending bits whether or not they are enabled.

Top module: `gpio_irq_bank`

Register offsets (bytes): revision 0x000, raw pending line 0/1 at 0x024/0x028, masked status line 0/1 at 0x02C/0x030, enable-set line 0/1 at 0x034/0x038, enable-clear line 0/1 at 0x03C/0x040, direction 0x134, input view 0x138, output data 0x13C, low-level detect 0x140, high-level detect 0x144, rising detect 0x148, falling detect 0x14C, output clear alias 0x190, output set alias 0x194. Read data appears on `bus_rdata` one clock after the address is presented. Writes take effect at the clock edge where `bus_we` is high.

## Requirements
- R1: Direction bit 1 makes a pin an input and 0 makes it an output. After reset every direction bit is 1. `pin_dir` shows the direction register, and only a write to offset 0x134 changes it.
- R2: A write to 0x194 sets the output bits where the data has ones, and a write to 0x190 clears them. Zero bits leave the output alone. A write to 0x13C loads the whole output register. `pin_out` and a read of 0x13C both show the register.
- R3: A read of 0x138 returns, for each pin, the synchronised input level when the pin is an input, and the output register bit when it is an output.
- R4: For each line, a write to its enable-set offset ORs the data into that line's enable mask, and a write to its enable-clear offset removes the one bits. The two lines are independent. Reads of either alias return the mask, and writing all ones to both clear aliases leaves both masks zero.
- R5: Bit n of the registers at 0x140, 0x144, 0x148 and 0x14C enables, for pin n, detection of a low level, a high level, a 0-to-1 transition and a 1-to-0 transition. Any combination is allowed, and setting both edge bits detects either edge.
- R6: A detected event sets the pin's bit in both lines' pending vectors, and the bit stays set until cleared. The raw offsets 0x024 and 0x028 return the pending vectors whether or not any enable is set.
- R7: A read of 0x02C or 0x030 returns that line's pending bits ANDed with its enable mask. `irq_line[k]` is high one clock after any pending bit of line k has its enable bit set, and low one clock after none has.
- R8: Writing ones to a line's status offset clears those pending bits of that line only. An event detected in the same cycle as the clear keeps the bit set. A level condition that persists therefore sets the bit again straight away.
- R9: The revision register reads major number REV_MAJOR in bits 7:4 and minor number REV_MINOR in bits 3:0 (0x21 by default). Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the address |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data register |
| pin_dir | output | NPINS | Direction register, 1 = input |
| irq_line | output | 2 | Interrupt lines 0 and 1 |

## Verification
The detection logic is tried on one pin with all sixteen combinations of the four detect enables. Each combination goes through the same low-clear-high-clear-low sequence. The pending bit expected after every step is computed from the enable bits, which tells levels apart from edges and rising from falling. The clear step made while a level is still active shows that a persisting level wins over the clear. The output aliases are swept over every pin with overlapping patterns, so that any set or clear leaking into a neighbouring bit shows up. The input view is read under a mixed direction mask. Enables and clears are applied to one line and then the other, to show the lines are independent and that the interrupt outputs follow only the enabled pending bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NLINES = 2;
  localparam int unsigned LINE_STRIDE = 4;

  localparam int unsigned OFF_REV     = 'h000;
  localparam int unsigned OFF_RAW0    = 'h024;
  localparam int unsigned OFF_STAT0   = 'h02C;
  localparam int unsigned OFF_ENSET0  = 'h034;
  localparam int unsigned OFF_ENCLR0  = 'h03C;
  localparam int unsigned OFF_DIR     = 'h134;
  localparam int unsigned OFF_DIN     = 'h138;
  localparam int unsigned OFF_DOUT    = 'h13C;
  localparam int unsigned OFF_DET_LO  = 'h140;
  localparam int unsigned OFF_DET_HI  = 'h144;
  localparam int unsigned OFF_DET_RISE = 'h148;
  localparam int unsigned OFF_DET_FALL = 'h14C;
  localparam int unsigned OFF_DCLR    = 'h190;
  localparam int unsigned OFF_DSET    = 'h194;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level,
  input  logic [NPINS-1:0] det_lo,
  input  logic [NPINS-1:0] det_hi,
  input  logic [NPINS-1:0] det_rise,
  input  logic [NPINS-1:0] det_fall,
  output logic [NPINS-1:0] evt
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  always_comb begin
    evt = (det_lo   & ~level)
        | (det_hi   &  level)
        | (det_rise &  level & ~prev_q)
        | (det_fall & ~level &  prev_q);
  end
endmodule

// File: rtl/gpio_irq_set.sv
module gpio_irq_set #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] evt,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic             ack_we,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] en,
  output logic             irq
);
  logic [NPINS-1:0] ack_mask;

  assign ack_mask = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~ack_mask) | evt;
      if (en_set_we)      en <= en | wdata;
      else if (en_clr_we) en <= en & ~wdata;
      irq <= |(pend & en);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned REV_MAJOR = 2,
  parameter int unsigned REV_MINOR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_dir,
  output logic [1:0]        irq_line
);
  localparam logic [7:0] REV_WORD = {4'(REV_MAJOR), 4'(REV_MINOR)};

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] dir_q, dout_q, det_lo_q, det_hi_q, det_rise_q, det_fall_q;
  logic [NPINS-1:0] level_s, evt;
  logic [NPINS-1:0] pend [NLINES];
  logic [NPINS-1:0] en   [NLINES];
  logic [DATA_W-1:0] rd_next;

  assign wd = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q      <= '1;
      dout_q     <= '0;
      det_lo_q   <= '0;
      det_hi_q   <= '0;
      det_rise_q <= '0;
      det_fall_q <= '0;
    end else if (bus_we) begin
      if (at(bus_addr, OFF_DIR))      dir_q      <= wd;
      if (at(bus_addr, OFF_DOUT))     dout_q     <= wd;
      if (at(bus_addr, OFF_DSET))     dout_q     <= dout_q | wd;
      if (at(bus_addr, OFF_DCLR))     dout_q     <= dout_q & ~wd;
      if (at(bus_addr, OFF_DET_LO))   det_lo_q   <= wd;
      if (at(bus_addr, OFF_DET_HI))   det_hi_q   <= wd;
      if (at(bus_addr, OFF_DET_RISE)) det_rise_q <= wd;
      if (at(bus_addr, OFF_DET_FALL)) det_fall_q <= wd;
    end
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (level_s)
  );

  gpio_event_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .level    (level_s),
    .det_lo   (det_lo_q),
    .det_hi   (det_hi_q),
    .det_rise (det_rise_q),
    .det_fall (det_fall_q),
    .evt      (evt)
  );

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    localparam int unsigned STAT_OFF  = OFF_STAT0  + LINE_STRIDE * k;
    localparam int unsigned ENSET_OFF = OFF_ENSET0 + LINE_STRIDE * k;
    localparam int unsigned ENCLR_OFF = OFF_ENCLR0 + LINE_STRIDE * k;

    gpio_irq_set #(.NPINS(NPINS)) u_set (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt),
      .en_set_we (bus_we && at(bus_addr, ENSET_OFF)),
      .en_clr_we (bus_we && at(bus_addr, ENCLR_OFF)),
      .ack_we    (bus_we && at(bus_addr, STAT_OFF)),
      .wdata     (wd),
      .pend      (pend[k]),
      .en        (en[k]),
      .irq       (irq_line[k])
    );
  end

  always_comb begin
    rd_next = '0;
    if (at(bus_addr, OFF_REV))      rd_next = DATA_W'(REV_WORD);
    if (at(bus_addr, OFF_DIR))      rd_next = DATA_W'(dir_q);
    if (at(bus_addr, OFF_DIN))      rd_next = DATA_W'((level_s & dir_q) | (dout_q & ~dir_q));
    if (at(bus_addr, OFF_DOUT))     rd_next = DATA_W'(dout_q);
    if (at(bus_addr, OFF_DET_LO))   rd_next = DATA_W'(det_lo_q);
    if (at(bus_addr, OFF_DET_HI))   rd_next = DATA_W'(det_hi_q);
    if (at(bus_addr, OFF_DET_RISE)) rd_next = DATA_W'(det_rise_q);
    if (at(bus_addr, OFF_DET_FALL)) rd_next = DATA_W'(det_fall_q);
    for (int k = 0; k < NLINES; k++) begin
      if (at(bus_addr, OFF_RAW0 + LINE_STRIDE * k))
        rd_next = DATA_W'(pend[k]);
      if (at(bus_addr, OFF_STAT0 + LINE_STRIDE * k))
        rd_next = DATA_W'(pend[k] & en[k]);
      if (at(bus_addr, OFF_ENSET0 + LINE_STRIDE * k) || at(bus_addr, OFF_ENCLR0 + LINE_STRIDE * k))
        rd_next = DATA_W'(en[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pin_out = dout_q;
  assign pin_dir = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_dir,
  input logic [1:0]        irq_line,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  pend0,
  input logic [NPINS-1:0]  pend1,
  input logic [NPINS-1:0]  en0,
  input logic [NPINS-1:0]  en1
);
  localparam int unsigned GAP_OFF = 'h004;

  // R1
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(OFF_DIR)) |=> $stable(pin_dir));

  // R2
  dout_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_DSET)) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  // R2
  dout_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_DCLR)) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

  // R4
  en_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_ENCLR0) && bus_wdata == '1) |=> (en0 == '0));

  // R7
  irq0_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend0 & en0)) |=> irq_line[0]);

  // R7
  irq1_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend1 & en1)) |=> !irq_line[1]);

  // R8
  evt_kept0_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend0 & $past(evt)) == $past(evt)));

  // R8
  evt_kept1_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend1 & $past(evt)) == $past(evt)));

  // R9
  gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(GAP_OFF)) |=> (bus_rdata == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_dir   (pin_dir),
  .irq_line  (irq_line),
  .evt       (evt),
  .pend0     (pend[0]),
  .pend1     (pend[1]),
  .en0       (en[0]),
  .en1       (en[1])
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  localparam int unsigned A_REV = 'h000, A_RAW0 = 'h024, A_RAW1 = 'h028,
    A_ST0 = 'h02C, A_ST1 = 'h030, A_ES0 = 'h034, A_ES1 = 'h038,
    A_EC0 = 'h03C, A_EC1 = 'h040, A_DIR = 'h134, A_DIN = 'h138,
    A_DOUT = 'h13C, A_LO = 'h140, A_HI = 'h144, A_RISE = 'h148,
    A_FALL = 'h14C, A_DCLR = 'h190, A_DSET = 'h194;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_dir;
  logic [1:0]  irq_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, model, pat, dirm, bit5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state: all pins input
    chk("R1 reset dir", pin_dir, 32'hFFFF_FFFF);
    chk("R2 reset dout", pin_out, 32'h0);
    chk("R7 reset irq", 32'(irq_line), 32'h0);
    rd(A_REV, v);   chk("R9 revision", v, 32'h21);
    rd(A_RAW0, v);  chk("R6 reset raw0", v, 32'h0);

    // R2 set alias sweep with overlapping patterns
    model = '0;
    for (int i = 0; i < 32; i++) begin
      pat = (32'h1 << i) | (32'h1 << ((i * 7 + 3) % 32));
      wr(A_DSET, pat);
      model = model | pat;
      rd(A_DOUT, v);
      chk("R2 set alias", v, model);
    end
    // R2 clear alias sweep
    for (int i = 0; i < 32; i++) begin
      pat = 32'h1 << ((i * 5) % 32);
      wr(A_DCLR, pat);
      model = model & ~pat;
      chk("R2 clear alias", pin_out, model);
    end
    wr(A_DOUT, 32'hDEAD_BEEF);
    chk("R2 full load", pin_out, 32'hDEAD_BEEF);
    wr(A_DSET, 32'h0);
    chk("R2 zero set no effect", pin_out, 32'hDEAD_BEEF);

    // R1 direction write
    dirm = 32'h0000_FFFF;
    wr(A_DIR, dirm);
    chk("R1 dir port", pin_dir, dirm);
    rd(A_DIR, v); chk("R1 dir read", v, dirm);

    // R3 input view mux
    @(negedge clk); pin_in = 32'h1234_5678;
    idle(4);
    rd(A_DIN, v);
    chk("R3 mixed dir", v, (pin_in & dirm) | (32'hDEAD_BEEF & ~dirm));
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIN, v); chk("R3 all input", v, 32'h1234_5678);
    wr(A_DIR, 32'h0);
    rd(A_DIN, v); chk("R3 all output", v, 32'hDEAD_BEEF);
    wr(A_DIR, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = '0;

    // R4 enable aliases per line
    wr(A_ES0, 32'h0000_00F0);
    wr(A_ES0, 32'h0000_0F00);
    rd(A_ES0, v); chk("R4 en0 set", v, 32'h0000_0FF0);
    wr(A_EC0, 32'h0000_00C0);
    rd(A_EC0, v); chk("R4 en0 clear", v, 32'h0000_0F30);
    rd(A_ES1, v); chk("R4 en1 untouched", v, 32'h0);
    wr(A_ES1, 32'hA000_0001);
    rd(A_EC1, v); chk("R4 en1 set", v, 32'hA000_0001);
    rd(A_ES0, v); chk("R4 en0 untouched", v, 32'h0000_0F30);
    wr(A_EC0, 32'hFFFF_FFFF);
    wr(A_EC1, 32'hFFFF_FFFF);
    rd(A_ES0, v); chk("R4 en0 wiped", v, 32'h0);
    rd(A_ES1, v); chk("R4 en1 wiped", v, 32'h0);

    // R5 R6 R8 sweep over all detect combinations on pin 5
    bit5 = 32'h1 << 5;
    for (int m = 0; m < 16; m++) begin
      logic lo, hi, ri, fa;
      lo = m[0]; hi = m[1]; ri = m[2]; fa = m[3];
      wr(A_LO, 0); wr(A_HI, 0); wr(A_RISE, 0); wr(A_FALL, 0);
      @(negedge clk); pin_in = '0;
      idle(5);
      wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
      wr(A_RISE, ri ? bit5 : 0); wr(A_FALL, fa ? bit5 : 0);
      wr(A_HI, hi ? bit5 : 0);   wr(A_LO, lo ? bit5 : 0);
      idle(5);
      rd(A_RAW0, v); chk("R5 low level", v, lo ? bit5 : 0);
      rd(A_RAW1, v); chk("R6 both lines", v, lo ? bit5 : 0);
      wr(A_ST0, 32'hFFFF_FFFF); idle(5);
      rd(A_RAW0, v); chk("R8 clear vs level", v, lo ? bit5 : 0);
      @(negedge clk); pin_in = bit5; idle(5);
      rd(A_RAW0, v); chk("R5 rise/high", v, (lo | hi | ri) ? bit5 : 0);
      wr(A_ST0, 32'hFFFF_FFFF); idle(5);
      rd(A_RAW0, v); chk("R8 clear while high", v, hi ? bit5 : 0);
      @(negedge clk); pin_in = '0; idle(5);
      rd(A_RAW0, v); chk("R5 fall/low", v, (hi | fa | lo) ? bit5 : 0);
      chk("R7 no enable no irq", 32'(irq_line), 32'h0);
    end

    // R7 masked status and interrupt lines
    wr(A_LO, 0); wr(A_HI, 0); wr(A_RISE, 0); wr(A_FALL, 0);
    wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
    wr(A_HI, bit5);
    @(negedge clk); pin_in = bit5; idle(5);
    wr(A_HI, 0); idle(2);
    wr(A_ES1, bit5); idle(3);
    rd(A_ST1, v); chk("R7 status1 masked", v, bit5);
    rd(A_ST0, v); chk("R7 status0 masked", v, 32'h0);
    rd(A_RAW0, v); chk("R6 raw0 unmasked", v, bit5);
    chk("R7 irq line1 only", 32'(irq_line), 32'h2);
    wr(A_ST1, bit5); idle(3);
    rd(A_RAW1, v); chk("R8 line1 cleared", v, 32'h0);
    rd(A_RAW0, v); chk("R8 line0 kept", v, bit5);
    chk("R7 irq off", 32'(irq_line), 32'h0);
    wr(A_ES0, bit5); idle(3);
    chk("R7 irq line0", 32'(irq_line), 32'h1);

    // R9 unmapped offsets
    rd('h004, v); chk("R9 gap read", v, 32'h0);
    rd('h200, v); chk("R9 high read", v, 32'h0);
    wr('h008, 32'hFFFF_FFFF);
    chk("R9 unmapped write dout", pin_out, 32'hDEAD_BEEF);
    chk("R9 unmapped write dir", pin_dir, 32'hFFFF_FFFF);

    finish_run();
  end
endmodule